// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Replay

This block is a shared on-chip scratchpad that a group of SIMD lanes uses as working memory. In each accepted group, every enabled lane carries one operation: a read, a write or an atomic read-modify-write on a 32-bit word. The storage is split into word-wide banks. A lane's bank comes from the low bits of its word address. Lanes that land in different banks are served in the same cycle. Lanes that collide in one bank are replayed, one bank access per cycle, until the group has drained.

Requests enter through a valid/ready handshake that carries the whole lane group at once. The block accepts a group when `in_valid` and `in_ready` are both high on a rising clock edge. After that, `in_ready` stays low until the group has been fully served, so the producer must hold its next group until then. There is no output back-pressure. `done` pulses for one cycle when the last access has been made. From that cycle on, `lane_rdata` holds every lane's result until the next group is accepted. Each bank has its own atomic unit, so read-modify-write operations finish inside the bank in a single access. A parameter selects the full 32-bank configuration or a reduced 16-bank one.

Top module: `scratchpad_banked`

## Requirements
- R1: A word address selects bank `addr % BANKS`, and the row inside that bank is `addr / BANKS`. The stored contents are zero after reset.
- R2: `in_ready` is high when idle and drops on the cycle after a group is accepted. It stays low until `done`. A valid group offered while `in_ready` is low is neither accepted nor applied.
- R3: A group whose enabled lanes all use distinct banks is served in one cycle, so `done` rises on the second clock edge after acceptance.
- R4: If the group needs N distinct accesses in its busiest bank, it takes N serve cycles, and `done` rises N+1 edges after acceptance.
- R5: Reads (op 0) that share an address with the winning read in a bank are served in that same cycle and add no extra cycle.
- R6: In each serve cycle, the lowest-numbered pending lane of each bank wins. A winning write or atomic is served alone. Writes to one address therefore land in lane order, and the highest-numbered one is left in memory.
- R7: Op codes: 0 read, 1 write, 2 add, 3 subtract (old minus operand), 4 AND, 5 OR, 6 XOR, 7 unsigned min, 8 unsigned max, 9 compare-and-swap. An atomic returns the old word and stores its result in the same bank access. Codes 10 to 15 return the old word and store nothing.
- R8: Compare-and-swap stores `lane_wdata` only when the old word equals `lane_cmp`. It always returns the old word.
- R9: `done` is high for exactly one cycle per group. `lane_rdata` changes only while a group is being served, is cleared when a group is accepted, and holds its value from `done` until the next acceptance.
- R10: Disabled lanes neither read nor modify memory and return 0. Write lanes return 0. A group with no enabled lane completes in one serve cycle.
- R11: With `BANKS` = 16, the mapping of R1 uses 16 banks, so addresses 16 apart collide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A lane group is offered |
| in_ready | output | 1 | Block can accept a group |
| lane_en | input | LANES | Per-lane enable |
| lane_op | input | 4*LANES | Per-lane op code, lane l in bits [4l+3:4l] |
| lane_addr | input | ADDR_W*LANES | Per-lane word address |
| lane_wdata | input | DATA_W*LANES | Write data or atomic operand |
| lane_cmp | input | DATA_W*LANES | Compare value for compare-and-swap |
| done | output | 1 | One-cycle pulse when the group has drained |
| lane_rdata | output | DATA_W*LANES | Per-lane read data or old value |

## Verification
The bench drives groups that put every lane in one bank at distinct rows. A design that failed to serialize them would finish in one cycle and lose accesses, and a wrong count shows up as a `done` on the wrong edge. Groups that mix a broadcast read with a write to the same word catch a design that merges the write into the broadcast, or that replays the shared reads one at a time and spends extra cycles. Chains of same-address atomics and writes expose a wrong lane order through the sequence of returned old values and the surviving word. A group offered during replay, together with disabled lanes that carry write data, catches any leak of ignored requests into memory. Random conflicting groups on both bank counts compare cycle counts and results against a behavioural model.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
  typedef enum logic [3:0] {
    OP_READ  = 4'd0,
    OP_WRITE = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUB   = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_MINU  = 4'd7,
    OP_MAXU  = 4'd8,
    OP_CAS   = 4'd9
  } lane_op_e;
endpackage

// File: rtl/scratch_atomic_alu.sv
module scratch_atomic_alu
  import scratch_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] cmp_val,
  output logic [DATA_W-1:0] new_val,
  output logic              do_write
);
  always_comb begin
    new_val  = old_val;
    do_write = 1'b1;
    case (op)
      OP_WRITE: new_val = operand;
      OP_ADD:   new_val = old_val + operand;
      OP_SUB:   new_val = old_val - operand;
      OP_AND:   new_val = old_val & operand;
      OP_OR:    new_val = old_val | operand;
      OP_XOR:   new_val = old_val ^ operand;
      OP_MINU:  new_val = (operand < old_val) ? operand : old_val;
      OP_MAXU:  new_val = (operand > old_val) ? operand : old_val;
      OP_CAS: begin
        new_val  = operand;
        do_write = (old_val == cmp_val);
      end
      default:  do_write = 1'b0;  // read and unused codes leave the word alone
    endcase
  end
endmodule

// File: rtl/scratch_bank.sv
module scratch_bank #(
  parameter int DATA_W = 32,
  parameter int ROWS   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_en,
  input  logic [3:0]                acc_op,
  input  logic [$clog2(ROWS)-1:0]   acc_row,
  input  logic [DATA_W-1:0]         acc_wdata,
  input  logic [DATA_W-1:0]         acc_cmp,
  output logic [DATA_W-1:0]         acc_old
);
  logic [DATA_W-1:0] mem_q [ROWS];
  logic [DATA_W-1:0] alu_res;
  logic              alu_wr;

  // one word port: old value is read in the access cycle, result lands at the edge
  assign acc_old = mem_q[acc_row];

  scratch_atomic_alu #(.DATA_W(DATA_W)) alu_i (
    .op       (acc_op),
    .old_val  (acc_old),
    .operand  (acc_wdata),
    .cmp_val  (acc_cmp),
    .new_val  (alu_res),
    .do_write (alu_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (acc_en && alu_wr) begin
      mem_q[acc_row] <= alu_res;
    end
  end
endmodule

// File: rtl/scratch_bank_arb.sv
module scratch_bank_arb
  import scratch_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int BANKS   = 32,
  parameter int ADDR_W  = 9,
  parameter int BANK_ID = 0,
  localparam int LIDX_W = $clog2(LANES),
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic [LANES-1:0]             pend,
  input  logic [LANES-1:0][ADDR_W-1:0] addr,
  input  logic [LANES-1:0][3:0]        op,
  output logic                         win_valid,
  output logic [LIDX_W-1:0]            win_idx,
  output logic [LANES-1:0]             grant
);
  logic [LANES-1:0] hit;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      hit[l] = pend[l] && (addr[l][BANK_W-1:0] == BANK_W'(BANK_ID));

    // lowest-numbered pending lane of this bank wins
    win_valid = 1'b0;
    win_idx   = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (hit[l]) begin
        win_valid = 1'b1;
        win_idx   = LIDX_W'(l);
      end
    end

    // a winning read carries every pending read of the same word with it
    grant = '0;
    for (int l = 0; l < LANES; l++) begin
      if (hit[l]) begin
        if (LIDX_W'(l) == win_idx)
          grant[l] = 1'b1;
        else if (op[win_idx] == OP_READ && op[l] == OP_READ && addr[l] == addr[win_idx])
          grant[l] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/scratchpad_banked.sv
module scratchpad_banked
  import scratch_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int BANKS  = 32,
  parameter int ROWS   = 16,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(BANKS * ROWS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES-1:0]          lane_en,
  input  logic [LANES*4-1:0]        lane_op,
  input  logic [LANES*ADDR_W-1:0]   lane_addr,
  input  logic [LANES*DATA_W-1:0]   lane_wdata,
  input  logic [LANES*DATA_W-1:0]   lane_cmp,
  output logic                      done,
  output logic [LANES*DATA_W-1:0]   lane_rdata
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int LIDX_W = $clog2(LANES);

  // captured group
  logic                            busy_q;
  logic                            done_q;
  logic [LANES-1:0]                pend_q;
  logic [LANES-1:0][3:0]           op_q;
  logic [LANES-1:0][ADDR_W-1:0]    addr_q;
  logic [LANES-1:0][DATA_W-1:0]    wd_q;
  logic [LANES-1:0][DATA_W-1:0]    cmp_q;
  logic [LANES-1:0][DATA_W-1:0]    res_q;

  // per-bank arbitration and access
  logic [BANKS-1:0]                win_valid;
  logic [LIDX_W-1:0]               win_idx   [BANKS];
  logic [LANES-1:0]                grant_b   [BANKS];
  logic [DATA_W-1:0]               bank_old  [BANKS];
  logic [LANES-1:0]                grant_all;
  logic [LANES-1:0]                pend_left;
  logic                            accept;

  assign accept    = in_valid && !busy_q;
  assign in_ready  = !busy_q;
  assign done      = done_q;
  assign pend_left = pend_q & ~grant_all;

  for (genvar l = 0; l < LANES; l++) begin : g_lane_io
    assign lane_rdata[l*DATA_W +: DATA_W] = res_q[l];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LIDX_W-1:0] w;
    assign w = win_idx[b];

    scratch_bank_arb #(
      .LANES   (LANES),
      .BANKS   (BANKS),
      .ADDR_W  (ADDR_W),
      .BANK_ID (b)
    ) arb_i (
      .pend      (pend_q),
      .addr      (addr_q),
      .op        (op_q),
      .win_valid (win_valid[b]),
      .win_idx   (win_idx[b]),
      .grant     (grant_b[b])
    );

    scratch_bank #(
      .DATA_W (DATA_W),
      .ROWS   (ROWS)
    ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_en    (busy_q && win_valid[b]),
      .acc_op    (op_q[w]),
      .acc_row   (addr_q[w][ADDR_W-1:BANK_W]),
      .acc_wdata (wd_q[w]),
      .acc_cmp   (cmp_q[w]),
      .acc_old   (bank_old[b])
    );
  end

  always_comb begin
    grant_all = '0;
    for (int b = 0; b < BANKS; b++) grant_all |= grant_b[b];
  end

  // control: accept, replay, pulse done
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        pend_q <= lane_en;
      end else if (busy_q) begin
        pend_q <= pend_left;
        if (pend_left == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // request capture and per-lane results
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      cmp_q  <= '0;
    end else if (accept) begin
      res_q <= '0;
      for (int l = 0; l < LANES; l++) begin
        op_q[l]   <= lane_op[l*4 +: 4];
        addr_q[l] <= lane_addr[l*ADDR_W +: ADDR_W];
        wd_q[l]   <= lane_wdata[l*DATA_W +: DATA_W];
        cmp_q[l]  <= lane_cmp[l*DATA_W +: DATA_W];
      end
    end else if (busy_q) begin
      for (int l = 0; l < LANES; l++) begin
        if (grant_all[l] && op_q[l] != OP_WRITE)
          res_q[l] <= bank_old[addr_q[l][BANK_W-1:0]];
      end
    end
  end

  logic unused_row;
  assign unused_row = ^ROW_W;
endmodule

// File: rtl/scratchpad_banked_chk.sv
module scratchpad_banked_chk #(
  parameter int LANES  = 8,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    done,
  input logic                    busy_q,
  input logic [LANES-1:0]        pend_q,
  input logic [LANES-1:0]        grant_all,
  input logic [LANES*DATA_W-1:0] lane_rdata
);
  // R2: an accepted group closes the input on the next cycle
  p_accept_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9: done never lasts two cycles
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done only ends a replay
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy_q));

  // R9: results hold while no group is in flight
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !(in_valid && in_ready)) |=> $stable(lane_rdata));

  // R6: only pending lanes are served
  p_grant_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((grant_all & ~pend_q) == '0));

  // R4: every replay cycle with work left serves at least one lane
  p_progress_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pend_q != '0) |-> (grant_all != '0));
endmodule

bind scratchpad_banked scratchpad_banked_chk #(
  .LANES  (LANES),
  .DATA_W (DATA_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .done       (done),
  .busy_q     (busy_q),
  .pend_q     (pend_q),
  .grant_all  (grant_all),
  .lane_rdata (lane_rdata)
);

// File: tb/scratchpad_banked_tb_top.sv
module scratchpad_banked_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 8;
  localparam int DW = 32;
  localparam int RW = 16;
  localparam int AW32 = 9;
  localparam int AW16 = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            in_valid = 1'b0;
  logic            sel16 = 1'b0;
  logic [L-1:0]    v_en = '0;
  logic [L*4-1:0]  v_op = '0;
  logic [L*AW32-1:0] v_addr32 = '0;
  logic [L*AW16-1:0] v_addr16 = '0;
  logic [L*DW-1:0] v_wd = '0;
  logic [L*DW-1:0] v_cmp = '0;

  logic            rdy32, rdy16, done32, done16;
  logic [L*DW-1:0] rd32, rd16;

  scratchpad_banked #(.LANES(L), .BANKS(32), .ROWS(RW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && !sel16), .in_ready(rdy32),
    .lane_en(v_en), .lane_op(v_op), .lane_addr(v_addr32), .lane_wdata(v_wd),
    .lane_cmp(v_cmp), .done(done32), .lane_rdata(rd32));

  scratchpad_banked #(.LANES(L), .BANKS(16), .ROWS(RW), .DATA_W(DW)) dut16_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && sel16), .in_ready(rdy16),
    .lane_en(v_en), .lane_op(v_op), .lane_addr(v_addr16), .lane_wdata(v_wd),
    .lane_cmp(v_cmp), .done(done16), .lane_rdata(rd16));

  // stimulus of one group
  bit          g_en  [L];
  int          g_op  [L];
  int          g_addr[L];
  logic [31:0] g_wd  [L];
  logic [31:0] g_cmp [L];

  // behavioural memories, absent key reads as zero
  logic [31:0] mem32 [int];
  logic [31:0] mem16 [int];

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mget(input int a);
    if (sel16) return mem16.exists(a) ? mem16[a] : 32'd0;
    return mem32.exists(a) ? mem32[a] : 32'd0;
  endfunction

  function automatic void mput(input int a, input logic [31:0] v);
    if (sel16) mem16[a] = v; else mem32[a] = v;
  endfunction

  function automatic logic cur_rdy();  return sel16 ? rdy16 : rdy32;  endfunction
  function automatic logic cur_done(); return sel16 ? done16 : done32; endfunction
  function automatic logic [31:0] cur_rd(input int l);
    return sel16 ? rd16[l*DW +: DW] : rd32[l*DW +: DW];
  endfunction

  // reference: serve the group bank by bank, cycle by cycle
  task automatic model(output int cycles, output logic [31:0] res[L]);
    int nb;
    int span;
    bit pend[L];
    bit gr[L];
    bit any;
    nb = sel16 ? 16 : 32;
    span = nb * RW;
    cycles = 0;
    for (int l = 0; l < L; l++) begin pend[l] = g_en[l]; res[l] = 32'd0; end
    forever begin
      any = 1'b0;
      for (int l = 0; l < L; l++) any |= pend[l];
      if (!any) break;
      cycles++;
      for (int l = 0; l < L; l++) gr[l] = 1'b0;
      for (int b = 0; b < nb; b++) begin
        int w;
        w = -1;
        for (int l = 0; l < L; l++)
          if (w < 0 && pend[l] && (g_addr[l] % span) % nb == b) w = l;
        if (w >= 0) begin
          int a;
          logic [31:0] old;
          logic [31:0] nv;
          bit wr;
          a = g_addr[w] % span;
          old = mget(a);
          if (g_op[w] == 0) begin
            for (int l = 0; l < L; l++)
              if (pend[l] && g_op[l] == 0 && (g_addr[l] % span) == a) begin
                gr[l] = 1'b1; res[l] = old;
              end
          end else begin
            gr[w] = 1'b1;
            if (g_op[w] != 1) res[w] = old;
            wr = 1'b1; nv = old;
            case (g_op[w])
              1: nv = g_wd[w];
              2: nv = old + g_wd[w];
              3: nv = old - g_wd[w];
              4: nv = old & g_wd[w];
              5: nv = old | g_wd[w];
              6: nv = old ^ g_wd[w];
              7: nv = (g_wd[w] < old) ? g_wd[w] : old;
              8: nv = (g_wd[w] > old) ? g_wd[w] : old;
              9: begin nv = g_wd[w]; wr = (old == g_cmp[w]); end
              default: wr = 1'b0;
            endcase
            if (wr) mput(a, nv);
          end
        end
      end
      for (int l = 0; l < L; l++) if (gr[l]) pend[l] = 1'b0;
    end
    if (cycles == 0) cycles = 1;
  endtask

  task automatic drive_group();
    for (int l = 0; l < L; l++) begin
      v_en[l] = g_en[l];
      v_op[l*4 +: 4] = 4'(g_op[l]);
      v_addr32[l*AW32 +: AW32] = AW32'(g_addr[l]);
      v_addr16[l*AW16 +: AW16] = AW16'(g_addr[l]);
      v_wd[l*DW +: DW] = g_wd[l];
      v_cmp[l*DW +: DW] = g_cmp[l];
    end
  endtask

  // offers the current group, checks ready/done on every clock and results at done
  task automatic run_group(input string req, input bit junk_while_busy);
    int n;
    logic [31:0] er[L];
    model(n, er);
    @(negedge clk);
    drive_group();
    in_valid = 1'b1;
    chk(req, "ready before accept", 32'(cur_rdy()), 32'd1);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (j == 0) begin
        if (junk_while_busy) begin
          // R2: a different group held valid during replay must be dropped
          for (int l = 0; l < L; l++) begin
            v_en[l] = 1'b1;
            v_op[l*4 +: 4] = 4'd1;
            v_wd[l*DW +: DW] = 32'hDEAD_0000 + 32'(l);
          end
        end else in_valid = 1'b0;
      end
      chk(req, "ready during replay", 32'(cur_rdy()), 32'd0);
      chk(req, "done during replay", 32'(cur_done()), 32'd0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "done at end", 32'(cur_done()), 32'd1);
    chk(req, "ready at end", 32'(cur_rdy()), 32'd1);
    for (int l = 0; l < L; l++) chk(req, $sformatf("lane %0d data", l), cur_rd(l), er[l]);
  endtask

  task automatic clear_group();
    for (int l = 0; l < L; l++) begin
      g_en[l] = 1'b0; g_op[l] = 0; g_addr[l] = 0; g_wd[l] = 32'd0; g_cmp[l] = 32'd0;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R2 R9: reset state
    chk("R2", "reset ready", 32'(rdy32), 32'd1);
    chk("R9", "reset done", 32'(done32), 32'd0);
    chk("R9", "reset rdata lane0", rd32[31:0], 32'd0);

    // R1: zero after reset, then fill distinct banks in one cycle (R3)
    clear_group();
    for (int l = 0; l < L; l++) begin g_en[l] = 1; g_op[l] = 0; g_addr[l] = 33 * l; end
    run_group("R1", 0);
    for (int l = 0; l < L; l++) begin g_op[l] = 1; g_wd[l] = 32'h100 + 32'(l); end
    run_group("R3", 0);
    for (int l = 0; l < L; l++) g_op[l] = 0;
    run_group("R1", 0);
    @(negedge clk);
    chk("R9", "done falls", 32'(done32), 32'd0);
    chk("R9", "rdata held lane3", rd32[3*DW +: DW], 32'h103);

    // R4: every lane in bank 3, distinct rows, write then read
    for (int l = 0; l < L; l++) begin g_op[l] = 1; g_addr[l] = 3 + 32 * l; g_wd[l] = 32'hA0 + 32'(l); end
    run_group("R4", 0);
    for (int l = 0; l < L; l++) g_op[l] = 0;
    run_group("R4", 0);

    // R5: all lanes read one word
    for (int l = 0; l < L; l++) g_addr[l] = 35;
    run_group("R5", 0);

    // R5 R6: broadcast reads with a write to the same word in between
    clear_group();
    g_en[0] = 1; g_op[0] = 0; g_addr[0] = 37;
    g_en[1] = 1; g_op[1] = 1; g_addr[1] = 37; g_wd[1] = 32'h55;
    g_en[2] = 1; g_op[2] = 0; g_addr[2] = 37;
    g_en[3] = 1; g_op[3] = 0; g_addr[3] = 69;
    run_group("R6", 0);

    // R6: same-address writes land in lane order
    clear_group();
    for (int l = 0; l < 4; l++) begin g_en[l] = 1; g_op[l] = 1; g_addr[l] = 40; g_wd[l] = 32'h700 + 32'(l); end
    run_group("R6", 0);
    g_op[0] = 0; g_en[1] = 0; g_en[2] = 0; g_en[3] = 0;
    run_group("R6", 0);

    // R7: atomic add chain on one word returns successive old values
    clear_group();
    for (int l = 0; l < L; l++) begin g_en[l] = 1; g_op[l] = 2; g_addr[l] = 64; g_wd[l] = 32'(l + 1); end
    run_group("R7", 0);

    // R7: each op on its own bank, seeded first
    clear_group();
    for (int l = 0; l < L; l++) begin g_en[l] = 1; g_op[l] = 1; g_addr[l] = 100 + l; g_wd[l] = 32'h0000_F0F0; end
    run_group("R7", 0);
    for (int l = 0; l < L; l++) begin g_op[l] = 3 + l; g_wd[l] = 32'h0000_0FF0 + 32'(l); end
    g_op[6] = 15;
    g_op[7] = 3;
    run_group("R7", 0);
    for (int l = 0; l < L; l++) g_op[l] = 0;
    run_group("R7", 0);

    // R8: compare-and-swap hit then miss
    clear_group();
    g_en[0] = 1; g_op[0] = 9; g_addr[0] = 200; g_cmp[0] = 32'd0; g_wd[0] = 32'hCAFE;
    g_en[1] = 1; g_op[1] = 9; g_addr[1] = 200; g_cmp[1] = 32'd0; g_wd[1] = 32'hBEEF;
    g_en[2] = 1; g_op[2] = 9; g_addr[2] = 201; g_cmp[2] = 32'd7; g_wd[2] = 32'h1234;
    run_group("R8", 0);
    g_op[0] = 0; g_op[1] = 0; g_op[2] = 0;
    run_group("R8", 0);

    // R10: disabled lanes carrying writes, and an empty group
    clear_group();
    for (int l = 0; l < L; l++) begin g_en[l] = (l % 2 == 0); g_op[l] = 1; g_addr[l] = 300 + l; g_wd[l] = 32'hBAD; end
    for (int l = 0; l < L; l += 2) g_op[l] = 0;
    run_group("R10", 0);
    for (int l = 0; l < L; l++) begin g_en[l] = 1; g_op[l] = 0; end
    run_group("R10", 0);
    clear_group();
    run_group("R10", 0);

    // R2: group held valid through replay is not applied
    clear_group();
    for (int l = 0; l < 3; l++) begin g_en[l] = 1; g_op[l] = 0; g_addr[l] = 5 + 32 * l; end
    for (int l = 0; l < L; l++) g_addr[l] = 5 + 32 * (l % 3);
    run_group("R2", 1);
    for (int l = 0; l < L; l++) begin g_en[l] = 1; g_op[l] = 0; end
    run_group("R2", 0);

    // R11: 16-bank instance, addresses 16 apart collide
    sel16 = 1'b1;
    clear_group();
    for (int l = 0; l < 4; l++) begin g_en[l] = 1; g_op[l] = 1; g_addr[l] = 16 * l + 2; g_wd[l] = 32'h60 + 32'(l); end
    run_group("R11", 0);
    for (int l = 0; l < 4; l++) g_op[l] = 0;
    run_group("R11", 0);

    // random conflicting groups on both bank counts
    for (int t = 0; t < 80; t++) begin
      sel16 = (t % 2 == 1);
      for (int l = 0; l < L; l++) begin
        g_en[l]   = ($urandom_range(0, 4) != 0);
        g_op[l]   = ($urandom_range(0, 10) == 10) ? 15 : int'($urandom_range(0, 9));
        g_addr[l] = int'($urandom_range(0, 2)) + 32 * int'($urandom_range(0, 1)) + 16 * int'($urandom_range(0, 1));
        g_wd[l]   = $urandom_range(0, 7);
        g_cmp[l]  = $urandom_range(0, 7);
      end
      run_group(sel16 ? "R11" : "R4", 0);
    end

    finish_run();
  end
endmodule